// File: doc/BRIEF.md
# Two-Threshold Cluster Hit Selector

This block sits in a self-triggered front-end chip that reads a one-dimensional row of strip channels. For each time window it receives one amplitude per channel together with a strobe, and decides which channels are worth sending on. Two thresholds drive that decision. An amplitude at or above the high threshold marks a particle, and that hit is always kept. The hit also opens a region of interest of `RADIUS` channels on each side of its own channel. An amplitude that reaches only the low threshold is a candidate cluster tail. It is kept only when some region of interest covers its channel.

Strip clusters often straddle two chips. A region that spills past channel 0 or past the last channel is flagged on a boundary output toward that neighbour. A neighbour's flag, arriving on a boundary input, opens the `RADIUS` channels nearest that edge on this chip. Channel 0 is the left edge and channel `NCH-1` is the right edge.

The decision is published in two forms. The first is a selection mask, one bit per channel. The second is a list of hits, each giving a channel and its amplitude, emitted one per cycle in ascending channel order.

The controller is a three-state machine:

- IDLE waits for the strobe. On the strobe it captures the amplitudes, the threshold comparisons, the thresholds and the neighbour flags, then moves to CLASSIFY.
- CLASSIFY builds the regions and registers the mask and the boundary flags. It moves to EMIT when the mask is not empty, and back to IDLE when it is.
- EMIT sends the lowest pending channel on each cycle. It returns to IDLE on the cycle that sends the last one.

Top module: `cluster_hit_selector`

## Requirements
- R1: A channel whose amplitude is greater than or equal to `thr_hi` always has its `sel_mask` bit set and is emitted as a hit.
- R2: A channel with `thr_lo` <= amplitude < `thr_hi` is selected if and only if its region check passes. The check passes when a channel of this chip at distance at most `RADIUS` holds a high hit, or when the channel lies in a neighbour-enabled edge zone (R5).
- R3: A channel with amplitude below `thr_lo` is never selected, even inside a region of interest.
- R4: `roi_out_left` is set for a window if and only if a high hit lies in channels 0..RADIUS-1. `roi_out_right` is set if and only if a high hit lies in channels NCH-RADIUS..NCH-1. Both are updated together with `sel_mask`. Neighbour requests on the inputs are not echoed on these outputs.
- R5: `roi_in_left`, sampled with the strobe, opens channels 0..RADIUS-1 only. `roi_in_right` opens channels NCH-RADIUS..NCH-1 only. Either input can validate only low hits.
- R6: With the strobe sampled at clock edge k, `mask_valid` is high for exactly one cycle after edge k+1, with `sel_mask` and the boundary outputs updated at that same edge. The first hit is presented after edge k+2.
- R7: Hits appear with `hit_valid` high on consecutive cycles, one per selected channel, in strictly ascending `hit_chan` order. Each hit carries its captured amplitude on `hit_amp`. `hit_last` marks the final hit of the window, and `hit_valid` falls on the next cycle.
- R8: A strobe that arrives while the machine is not in IDLE is ignored. It produces no extra mask pulse and no extra hits.
- R9: While reset is active, and right after it, `hit_valid`, `hit_last`, `mask_valid`, `sel_mask` and both boundary outputs are 0.
- R10: A window with no selected channel gives one `mask_valid` pulse with an all-zero mask and no hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Starts a window; inputs captured at this edge |
| amp_in | input | NCH*AW | Channel amplitudes, channel i at bits [i*AW +: AW] |
| thr_hi | input | AW | High (particle) threshold |
| thr_lo | input | AW | Low (tail) threshold |
| roi_in_left | input | 1 | Region request from the left neighbour |
| roi_in_right | input | 1 | Region request from the right neighbour |
| roi_out_left | output | 1 | Region reaches past channel 0 |
| roi_out_right | output | 1 | Region reaches past channel NCH-1 |
| mask_valid | output | 1 | One-cycle pulse: sel_mask updated |
| sel_mask | output | NCH | Selected channels of the last window |
| hit_valid | output | 1 | A hit is presented |
| hit_chan | output | $clog2(NCH) | Channel of the hit |
| hit_amp | output | AW | Amplitude of the hit |
| hit_last | output | 1 | Final hit of the window |

## Verification
The bench places low hits exactly `RADIUS` and `RADIUS+1` channels from a high hit. A region that is one channel too wide or too narrow therefore shows up as an extra or a missing channel. It also sets amplitudes exactly equal to each threshold, so a strict comparison drops those hits.

Other stimuli target the chip edges. High hits sit on the outermost channels, and neighbour requests arrive with and without eligible low hits. A design that swaps the edge zones, echoes requests outward, or lets a request validate sub-threshold channels then produces a wrong mask or wrong boundary flags.

A full window of sixteen hits, with a second strobe fired in the middle of it, catches three faults:
- emission out of order
- a lost or repeated channel
- a machine that restarts on a busy strobe

An empty window checks that no phantom hit follows the mask pulse.

// File: rtl/chs_pkg.sv
package chs_pkg;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_CLASSIFY = 2'd1,
        S_EMIT     = 2'd2
    } chs_state_e;

endpackage

// File: rtl/chs_classify.sv
module chs_classify #(
    parameter int NCH = 16,
    parameter int AW  = 8
) (
    input  logic [NCH*AW-1:0] amp_flat,
    input  logic [AW-1:0]     thr_hi,
    input  logic [AW-1:0]     thr_lo,
    output logic [NCH-1:0]    hi_vec,
    output logic [NCH-1:0]    lo_vec
);
    // one comparator pair per channel; equality counts as reaching a threshold
    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        logic [AW-1:0] a;
        assign a         = amp_flat[i*AW +: AW];
        assign hi_vec[i] = (a >= thr_hi);
        assign lo_vec[i] = (a >= thr_lo);
    end
endmodule

// File: rtl/chs_roi.sv
module chs_roi #(
    parameter int NCH    = 16,
    parameter int RADIUS = 2
) (
    input  logic [NCH-1:0] hi_vec,
    input  logic           nb_left,
    input  logic           nb_right,
    output logic [NCH-1:0] roi_vec,
    output logic           edge_left,
    output logic           edge_right
);
    localparam int PW  = NCH + 2 * RADIUS;
    localparam int WIN = 2 * RADIUS + 1;

    // padded[p] holds the high flag of channel p-RADIUS
    logic [PW-1:0] padded;
    assign padded = {{RADIUS{1'b0}}, hi_vec, {RADIUS{1'b0}}};

    for (genvar i = 0; i < NCH; i++) begin : g_win
        localparam logic IN_L = (i < RADIUS);
        localparam logic IN_R = (i >= NCH - RADIUS);
        logic near;
        assign near       = |padded[i +: WIN];
        assign roi_vec[i] = near | (IN_L & nb_left) | (IN_R & nb_right);
    end

    // a high hit this close to an edge spills its region onto the neighbour
    assign edge_left  = |hi_vec[RADIUS-1:0];
    assign edge_right = |hi_vec[NCH-1 -: RADIUS];
endmodule

// File: rtl/chs_scan.sv
module chs_scan #(
    parameter int NCH = 16,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] vec,
    output logic [IW-1:0]  idx,
    output logic [NCH-1:0] rest
);
    // lowest set bit wins, so the list leaves in ascending channel order
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (vec[i]) idx = i[IW-1:0];
        end
    end

    assign rest = vec & (vec - 1'b1);
endmodule

// File: rtl/cluster_hit_selector.sv
module cluster_hit_selector
    import chs_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int AW     = 8,
    parameter int RADIUS = 2,
    localparam int IW    = $clog2(NCH),
    localparam int FW    = NCH * AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic [FW-1:0]  amp_in,
    input  logic [AW-1:0]  thr_hi,
    input  logic [AW-1:0]  thr_lo,
    input  logic           roi_in_left,
    input  logic           roi_in_right,
    output logic           roi_out_left,
    output logic           roi_out_right,
    output logic           mask_valid,
    output logic [NCH-1:0] sel_mask,
    output logic           hit_valid,
    output logic [IW-1:0]  hit_chan,
    output logic [AW-1:0]  hit_amp,
    output logic           hit_last
);

    chs_state_e     state_q, state_d;

    logic [FW-1:0]  cap_amp_q;
    logic [NCH-1:0] hi_q, lo_q, pend_q;
    logic           nbl_q, nbr_q;
    logic [AW-1:0]  thr_lo_q;

    logic [NCH-1:0] hi_now, lo_now;
    logic [NCH-1:0] roi_vec, sel_d, rest;
    logic           edge_l, edge_r;
    logic [IW-1:0]  idx;
    logic [AW-1:0]  amp_pick;

    chs_classify #(.NCH(NCH), .AW(AW)) u_cls (
        .amp_flat (amp_in),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .hi_vec   (hi_now),
        .lo_vec   (lo_now)
    );

    chs_roi #(.NCH(NCH), .RADIUS(RADIUS)) u_roi (
        .hi_vec     (hi_q),
        .nb_left    (nbl_q),
        .nb_right   (nbr_q),
        .roi_vec    (roi_vec),
        .edge_left  (edge_l),
        .edge_right (edge_r)
    );

    // high hits always pass; tail hits need a region
    assign sel_d = hi_q | (lo_q & roi_vec);

    chs_scan #(.NCH(NCH)) u_scan (
        .vec  (pend_q),
        .idx  (idx),
        .rest (rest)
    );

    always_comb begin
        amp_pick = '0;
        for (int i = 0; i < NCH; i++) begin
            if (idx == i[IW-1:0]) amp_pick = cap_amp_q[i*AW +: AW];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (strobe) state_d = S_CLASSIFY;
            S_CLASSIFY: state_d = (sel_d != '0) ? S_EMIT : S_IDLE;
            S_EMIT:     if (rest == '0) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_amp_q     <= '0;
            hi_q          <= '0;
            lo_q          <= '0;
            pend_q        <= '0;
            nbl_q         <= 1'b0;
            nbr_q         <= 1'b0;
            thr_lo_q      <= '0;
            roi_out_left  <= 1'b0;
            roi_out_right <= 1'b0;
            mask_valid    <= 1'b0;
            sel_mask      <= '0;
            hit_valid     <= 1'b0;
            hit_chan      <= '0;
            hit_amp       <= '0;
            hit_last      <= 1'b0;
        end else begin
            mask_valid <= 1'b0;
            hit_valid  <= 1'b0;
            hit_last   <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (strobe) begin
                        cap_amp_q <= amp_in;
                        hi_q      <= hi_now;
                        lo_q      <= lo_now;
                        nbl_q     <= roi_in_left;
                        nbr_q     <= roi_in_right;
                        thr_lo_q  <= thr_lo;
                    end
                end
                S_CLASSIFY: begin
                    sel_mask      <= sel_d;
                    pend_q        <= sel_d;
                    mask_valid    <= 1'b1;
                    roi_out_left  <= edge_l;
                    roi_out_right <= edge_r;
                end
                S_EMIT: begin
                    hit_valid <= 1'b1;
                    hit_chan  <= idx;
                    hit_amp   <= amp_pick;
                    hit_last  <= (rest == '0);
                    pend_q    <= rest;
                end
                default: ;
            endcase
        end
    end

    // R7
    hit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_last) |=> (hit_valid && (hit_chan > $past(hit_chan))));

    // R7
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_last) |=> !hit_valid);

    // R7
    hit_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> sel_mask[hit_chan]);

    // R3
    low_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_amp >= thr_lo_q));

    // R6
    first_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_valid |=> (hit_valid == (sel_mask != '0)));

    // R8
    busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMIT) |=> (state_q != S_CLASSIFY));

    // R10
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && (sel_mask == '0)) |=> !hit_valid);

endmodule

// File: tb/cluster_hit_selector_bench.sv
module cluster_hit_selector_bench;
    localparam int NCH = 16;
    localparam int AW  = 8;
    localparam int R   = 2;
    localparam int IW  = $clog2(NCH);

    typedef struct packed {
        logic [IW-1:0] ch;
        logic [AW-1:0] amp;
        logic          last;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic [NCH*AW-1:0] amp_in = '0;
    logic [AW-1:0] thr_hi = '0, thr_lo = '0;
    logic roi_in_left = 1'b0, roi_in_right = 1'b0;
    logic roi_out_left, roi_out_right, mask_valid, hit_valid, hit_last;
    logic [NCH-1:0] sel_mask;
    logic [IW-1:0] hit_chan;
    logic [AW-1:0] hit_amp;

    cluster_hit_selector #(.NCH(NCH), .AW(AW), .RADIUS(R)) u_cluster_hit_selector (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .amp_in(amp_in),
        .thr_hi(thr_hi), .thr_lo(thr_lo),
        .roi_in_left(roi_in_left), .roi_in_right(roi_in_right),
        .roi_out_left(roi_out_left), .roi_out_right(roi_out_right),
        .mask_valid(mask_valid), .sel_mask(sel_mask),
        .hit_valid(hit_valid), .hit_chan(hit_chan),
        .hit_amp(hit_amp), .hit_last(hit_last)
    );

    always #10 clk = ~clk;

    int tests = 0, fails = 0;
    int cyc = 0;
    int mv_count = 0;
    int strobe_cyc = 0, prev_cyc = 0;
    bit first_exp = 1'b0;
    string cur_req = "";
    exp_t exp_q[$];

    logic [AW-1:0] a [NCH];
    logic [AW-1:0] th, tl;
    logic nbl, nbr;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor: pops expected hits as the design presents them
    always @(negedge clk) begin
        if (rst_n && mask_valid) mv_count++;
        if (rst_n && hit_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected hit chan", int'(hit_chan), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(hit_chan == e.ch, cur_req, "hit_chan", int'(hit_chan), int'(e.ch));
                check(hit_amp == e.amp, cur_req, "hit_amp", int'(hit_amp), int'(e.amp));
                check(hit_last == e.last, cur_req, "hit_last", int'(hit_last), int'(e.last));
                if (first_exp) begin
                    // R6 first hit two cycles after strobe edge
                    check(cyc == strobe_cyc + 2, "R6", "first hit cycle", cyc, strobe_cyc + 2);
                    first_exp = 1'b0;
                end else begin
                    // R7 consecutive
                    check(cyc == prev_cyc + 1, "R7", "hit spacing", cyc - prev_cyc, 1);
                end
                prev_cyc = cyc;
            end
        end
    end

    task automatic clear_amps();
        for (int i = 0; i < NCH; i++) a[i] = 8'd0;
        nbl = 1'b0;
        nbr = 1'b0;
        th = 8'd100;
        tl = 8'd30;
    endtask

    task automatic run_window(input string req, input bit busy);
        logic [NCH-1:0] hi, lo, sel;
        logic el, er;
        int mv_before;
        int last_i;
        hi = '0; lo = '0; sel = '0; el = 1'b0; er = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            hi[i] = (a[i] >= th);
            lo[i] = (a[i] >= tl);
        end
        for (int i = 0; i < NCH; i++) begin
            bit roi;
            roi = 1'b0;
            for (int j = 0; j < NCH; j++)
                if (hi[j] && (j - i <= R) && (i - j <= R)) roi = 1'b1;
            if (nbl && i < R) roi = 1'b1;
            if (nbr && i >= NCH - R) roi = 1'b1;
            sel[i] = hi[i] | (lo[i] & roi);
            if (hi[i] && i < R) el = 1'b1;
            if (hi[i] && i >= NCH - R) er = 1'b1;
        end
        last_i = -1;
        for (int i = 0; i < NCH; i++) if (sel[i]) last_i = i;
        for (int i = 0; i < NCH; i++)
            if (sel[i]) exp_q.push_back('{ch: i[IW-1:0], amp: a[i], last: (i == last_i)});
        cur_req = req;
        first_exp = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NCH; i++) amp_in[i*AW +: AW] = a[i];
        thr_hi = th;
        thr_lo = tl;
        roi_in_left = nbl;
        roi_in_right = nbr;
        strobe = 1'b1;
        strobe_cyc = cyc + 1;
        mv_before = mv_count;
        @(negedge clk);
        strobe = 1'b0;
        @(negedge clk);
        check(mask_valid == 1'b1, "R6", "mask_valid timing", int'(mask_valid), 1);
        check(sel_mask == sel, req, "sel_mask", int'(sel_mask), int'(sel));
        check(roi_out_left == el, "R4", "roi_out_left", int'(roi_out_left), int'(el));
        check(roi_out_right == er, "R4", "roi_out_right", int'(roi_out_right), int'(er));
        if (busy) begin
            // R8: second strobe while emitting
            for (int i = 0; i < NCH; i++) amp_in[i*AW +: AW] = 8'd5;
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
        end
        repeat (NCH + 6) @(negedge clk);
        check(exp_q.size() == 0, req, "missing hits", exp_q.size(), 0);
        exp_q.delete();
        check(mv_count == mv_before + 1, busy ? "R8" : req, "mask pulses",
              mv_count - mv_before, 1);
    endtask

    initial begin
        repeat (500000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check({hit_valid, hit_last, mask_valid, roi_out_left, roi_out_right} == 5'b0,
              "R9", "outputs in reset", int'({hit_valid, mask_valid}), 0);
        check(sel_mask == '0, "R9", "mask in reset", int'(sel_mask), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(hit_valid == 1'b0 && mask_valid == 1'b0, "R9", "after reset",
              int'(hit_valid), 0);

        // R1 R2 R3: interior cluster with radius and threshold boundaries
        clear_amps();
        a[7] = 8'd120; a[5] = 8'd40; a[9] = 8'd30; a[10] = 8'd50;
        a[4] = 8'd60;  a[11] = 8'd35; a[8] = 8'd10;
        run_window("R2", 1'b0);

        // R1 R4: high hit equal to threshold at left edge
        clear_amps();
        a[0] = 8'd100; a[1] = 8'd31; a[2] = 8'd44; a[3] = 8'd45;
        run_window("R1", 1'b0);

        // R4: right edge
        clear_amps();
        a[14] = 8'd200; a[11] = 8'd40; a[12] = 8'd40; a[13] = 8'd40; a[15] = 8'd40;
        run_window("R4", 1'b0);

        // R5: neighbour requests on both sides, no local high hit
        clear_amps();
        nbl = 1'b1; nbr = 1'b1;
        a[0] = 8'd50; a[1] = 8'd50; a[2] = 8'd50;
        a[13] = 8'd50; a[14] = 8'd50; a[15] = 8'd50;
        run_window("R5", 1'b0);

        // R3: neighbour request with only sub-threshold tails
        clear_amps();
        nbl = 1'b1;
        a[0] = 8'd29; a[1] = 8'd20;
        run_window("R3", 1'b0);

        // R10: empty window
        clear_amps();
        a[3] = 8'd29; a[9] = 8'd12;
        run_window("R10", 1'b0);

        // R7: every channel high
        clear_amps();
        for (int i = 0; i < NCH; i++) a[i] = 8'(150 + i);
        run_window("R7", 1'b0);

        // R8: full window with a strobe in the middle
        clear_amps();
        for (int i = 0; i < NCH; i++) a[i] = (i % 2 == 0) ? 8'd101 : 8'd33;
        run_window("R8", 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule